// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell

This block stands between core logic and a group of external pads. Four static configuration inputs shape its behaviour. On the drive side, core data can go to the pad directly or through a clocked output register. The driven level can be inverted. The output-enable polarity can also be inverted. When the resolved enable is inactive, the pad driver releases the line to high impedance.

On the receive side, the cell gives the core two copies of the pad at once: a direct, unclocked copy and a captured copy. The captured element works as a rising-edge flip-flop or as a latch that is transparent while its clock is high. A multiplexed external bus can therefore be split: one phase is held in the capture element while the other phase is read directly. The output register and the input capture element use separate clocks. A synchronous active-high reset clears both registers, and it also clears the latch whenever it is high.

Top module: `bidir_pad_cell`

## Requirements
- R1: In registered output mode (`cfg_out_reg`=1), the value driven to the pad is the `core_dout` sampled at the most recent rising edge of `clk_out`.
- R2: In direct output mode (`cfg_out_reg`=0), the value driven to the pad follows `core_dout` combinationally, with no clock edge needed.
- R3: With `cfg_dout_inv`=1, every driven pad bit is the complement of the selected data bit; with 0 it is the selected bit unchanged.
- R4: The driver of pad bit i is enabled exactly when `core_oe[i]` XOR `cfg_oe_inv` is 1.
- R5: When a bit's driver is disabled, the cell places no value on that pad, so an external source sets the line.
- R6: `in_direct` follows the resolved pad level at all times, including levels driven from outside while the output is disabled.
- R7: With `cfg_in_latch`=0, `in_captured` takes the pad value at each rising edge of `clk_in` and holds it between edges; `in_direct` stays live at the same time.
- R8: With `cfg_in_latch`=1, `in_captured` follows the pad while `clk_in` is high and holds the last value while `clk_in` is low.
- R9: `rst` high at a rising edge of `clk_out` clears the output register, and `rst` high at a rising edge of `clk_in` clears the input flip-flop. While `rst` is high, the input latch reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_out | input | 1 | Clock of the output register |
| clk_in | input | 1 | Clock of the input flip-flop; enable of the input latch |
| rst | input | 1 | Synchronous active-high global reset |
| cfg_out_reg | input | 1 | 1 selects the registered output, 0 the direct output |
| cfg_dout_inv | input | 1 | 1 inverts the level driven to the pad |
| cfg_oe_inv | input | 1 | 1 makes `core_oe` active-low |
| cfg_in_latch | input | 1 | 1 makes the input element a latch, 0 a flip-flop |
| core_dout | input | WIDTH | Data from core logic |
| core_oe | input | WIDTH | Per-bit output enable from core logic |
| pad | inout | WIDTH | External pad lines |
| in_direct | output | WIDTH | Unclocked copy of the pad |
| in_captured | output | WIDTH | Flip-flop or latch copy of the pad |

## Verification
Direct output and `in_direct` results are due in the same time step as their stimulus. The bench checks them 1 ns after it changes inputs on the falling edge of `clk_out`. Registered output results are due after the next rising edge of `clk_out`, so the bench checks them 1 ns past that edge, and before it, it checks that the old value still holds. The input path has a flip-flop result due one `clk_in` rising edge later and latch results due while `clk_in` is high. The bench drives `clk_in` itself and samples 1 ns after each level change.

// File: rtl/pad_cell_pkg.sv
package pad_cell_pkg;

    typedef struct packed {
        logic use_reg;
        logic invert_data;
        logic invert_oe;
    } drive_cfg_t;

    function automatic logic enable_resolved(input logic en, input logic inv);
        return en ^ inv;
    endfunction

endpackage

// File: rtl/pad_drive_path.sv
module pad_drive_path
    import pad_cell_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  drive_cfg_t       cfg,
    input  logic [WIDTH-1:0] core_dout,
    input  logic [WIDTH-1:0] core_oe,
    output logic [WIDTH-1:0] drv_val,
    output logic [WIDTH-1:0] drv_en
);

    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] chosen;

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= core_dout;
    end

    always_comb begin
        chosen = cfg.use_reg ? out_q : core_dout;
        for (int i = 0; i < WIDTH; i++) begin
            drv_val[i] = chosen[i] ^ cfg.invert_data;
            drv_en[i]  = enable_resolved(core_oe[i], cfg.invert_oe);
        end
    end

    // R1: register holds data sampled one clk edge earlier
    p_oreg_load_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_q == $past(core_dout));

    // R9: output register is zero after a reset edge
    p_oreg_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> out_q == '0);

endmodule

// File: rtl/pad_capture_path.sv
module pad_capture_path #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             latch_mode,
    input  logic [WIDTH-1:0] pad_val,
    output logic [WIDTH-1:0] direct,
    output logic [WIDTH-1:0] captured
);

    logic [WIDTH-1:0] ff_q;
    logic [WIDTH-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) ff_q <= '0;
        else     ff_q <= pad_val;
    end

    always_latch begin
        if (rst)      lat_q = '0;
        else if (clk) lat_q = pad_val;
    end

    assign direct   = pad_val;
    assign captured = latch_mode ? lat_q : ff_q;

    // R7: flip-flop holds the pad value seen at the previous edge
    p_iff_load_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ff_q == $past(pad_val));

    // R9: input flip-flop is zero after a reset edge
    p_iff_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ff_q == '0);

endmodule

// File: rtl/bidir_pad_cell.sv
module bidir_pad_cell
    import pad_cell_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk_out,
    input  logic             clk_in,
    input  logic             rst,
    input  logic             cfg_out_reg,
    input  logic             cfg_dout_inv,
    input  logic             cfg_oe_inv,
    input  logic             cfg_in_latch,
    input  logic [WIDTH-1:0] core_dout,
    input  logic [WIDTH-1:0] core_oe,
    inout  wire  [WIDTH-1:0] pad,
    output logic [WIDTH-1:0] in_direct,
    output logic [WIDTH-1:0] in_captured
);

    drive_cfg_t       dcfg;
    logic [WIDTH-1:0] drv_val;
    logic [WIDTH-1:0] drv_en;

    assign dcfg = '{use_reg: cfg_out_reg, invert_data: cfg_dout_inv, invert_oe: cfg_oe_inv};

    pad_drive_path #(.WIDTH(WIDTH)) u_drive (
        .clk       (clk_out),
        .rst       (rst),
        .cfg       (dcfg),
        .core_dout (core_dout),
        .core_oe   (core_oe),
        .drv_val   (drv_val),
        .drv_en    (drv_en)
    );

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_pad
            assign pad[g] = drv_en[g] ? drv_val[g] : 1'bz;

            // R4: an enabled driver sets the pad to the driven level
            p_pad_drive_r4: assert property (@(posedge clk_out) disable iff (rst)
                drv_en[g] |-> pad[g] == drv_val[g]);
        end
    endgenerate

    pad_capture_path #(.WIDTH(WIDTH)) u_capture (
        .clk        (clk_in),
        .rst        (rst),
        .latch_mode (cfg_in_latch),
        .pad_val    (pad),
        .direct     (in_direct),
        .captured   (in_captured)
    );

endmodule

// File: tb/sim_bidir_pad_cell.sv
module sim_bidir_pad_cell;

    localparam int W = 4;

    logic clk_out = 1'b0;
    logic clk_in  = 1'b0;
    logic rst     = 1'b1;
    logic c_reg = 0, c_inv = 0, c_oei = 0, c_lat = 0;
    logic [W-1:0] dout = '0, oe = '0;
    logic [W-1:0] ext_val = '0, ext_en = '0;
    wire  [W-1:0] pad;
    logic [W-1:0] in_direct, in_captured;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk_out = ~clk_out;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_ext
            assign pad[g] = ext_en[g] ? ext_val[g] : 1'bz;
        end
    endgenerate

    bidir_pad_cell #(.WIDTH(W)) u0 (
        .clk_out(clk_out), .clk_in(clk_in), .rst(rst),
        .cfg_out_reg(c_reg), .cfg_dout_inv(c_inv), .cfg_oe_inv(c_oei), .cfg_in_latch(c_lat),
        .core_dout(dout), .core_oe(oe), .pad(pad),
        .in_direct(in_direct), .in_captured(in_captured)
    );

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] expect_pad(input logic [W-1:0] data, input logic [W-1:0] en_v,
                                                 input logic inv, input logic oei,
                                                 input logic [W-1:0] ext);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++)
            r[i] = (en_v[i] ^ oei) ? (data[i] ^ inv) : ext[i];
        return r;
    endfunction

    task automatic set_ext_for(input logic [W-1:0] en_v, input logic oei, input logic [W-1:0] v);
        for (int i = 0; i < W; i++) ext_en[i] = ~(en_v[i] ^ oei);
        ext_val = v;
    endtask

    task automatic pulse_in;
        clk_in = 1'b1; #1;
        clk_in = 1'b0; #1;
    endtask

    initial begin
        logic [W-1:0] held;
        repeat (3) @(posedge clk_out);
        @(negedge clk_out);
        // R9: output register cleared by reset, registered mode shows zero
        c_reg = 1; oe = '1; dout = 4'hF; ext_en = '0;
        #1 chk("R9 out reg after reset", in_direct, 4'h0);
        pulse_in;
        chk("R9 input ff after reset", in_captured, 4'h0);
        rst = 0;
        @(posedge clk_out); #1;
        chk("R1 first capture", in_direct, 4'hF);
        held = 4'hF;

        // Sweep: all drive configurations, data and enable patterns
        for (int cf = 0; cf < 8; cf++) begin
            for (int d = 0; d < 16; d++) begin
                for (int e = 0; e < 16; e++) begin
                    logic [W-1:0] xv;
                    @(negedge clk_out);
                    c_reg = cf[0]; c_inv = cf[1]; c_oei = cf[2];
                    dout = d[W-1:0]; oe = e[W-1:0];
                    xv = ~d[W-1:0] ^ e[W-1:0];
                    set_ext_for(oe, c_oei, xv);
                    #1;
                    // R2 direct path immediate; R1 register not yet updated; R3, R4, R5, R6
                    chk(c_reg ? "R1 R3 R4 R5 R6 before edge" : "R2 R3 R4 R5 R6 immediate",
                        in_direct, expect_pad(c_reg ? held : dout, oe, c_inv, c_oei, xv));
                    @(posedge clk_out); #1;
                    held = dout;
                    chk("R1 R3 R4 R6 after edge", in_direct,
                        expect_pad(dout, oe, c_inv, c_oei, xv));
                end
            end
        end

        // R9: mid-run reset of output register
        @(negedge clk_out);
        c_reg = 1; c_inv = 0; c_oei = 0; oe = '1; ext_en = '0; dout = 4'hA;
        @(posedge clk_out); #1;
        chk("R1 load A", in_direct, 4'hA);
        @(negedge clk_out); rst = 1;
        @(posedge clk_out); #1;
        chk("R9 out reg cleared", in_direct, 4'h0);
        @(negedge clk_out); rst = 0;
        @(posedge clk_out); #1;
        chk("R9 out reg reload", in_direct, 4'hA);

        // Input path: output disabled, pad driven externally
        @(negedge clk_out);
        oe = '0; c_oei = 0; ext_en = '1;
        c_lat = 0;
        for (int v = 0; v < 16; v++) begin
            ext_val = v[W-1:0]; #1;
            chk("R6 direct external", in_direct, v[W-1:0]);
            pulse_in;
            chk("R7 ff captures", in_captured, v[W-1:0]);
            ext_val = ~v[W-1:0]; #1;
            chk("R7 ff holds", in_captured, v[W-1:0]);
            chk("R7 direct concurrent", in_direct, ~v[W-1:0]);
        end

        // R8 latch mode
        c_lat = 1;
        clk_in = 1; ext_val = 4'h3; #1;
        chk("R8 transparent", in_captured, 4'h3);
        ext_val = 4'hC; #1;
        chk("R8 transparent follow", in_captured, 4'hC);
        clk_in = 0; #1;
        ext_val = 4'h5; #1;
        chk("R8 hold low", in_captured, 4'hC);
        chk("R6 direct while latch holds", in_direct, 4'h5);

        // R9: latch cleared while reset high, ff cleared on edge
        rst = 1; #1;
        chk("R9 latch zero in reset", in_captured, 4'h0);
        c_lat = 0; pulse_in;
        chk("R9 input ff cleared", in_captured, 4'h0);
        rst = 0; #1;
        c_lat = 1; #1;
        chk("R9 latch stays cleared after reset", in_captured, 4'h0);
        clk_in = 1; #1;
        chk("R8 transparent after reset", in_captured, 4'h5);
        clk_in = 0; #1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule